// File: doc/BRIEF.md
# Convert-Edge Power Mode Controller

This block works out the low-power state of a sampling converter's digital side from nothing but the traffic on its two interface lines. Each cycle of the system clock it may see a one-cycle pulse marking a rising edge of the convert-start line and a one-cycle pulse marking a rising edge of the serial clock line. Both pulses arrive already synchronized. The block counts convert edges that arrive back to back, with no serial-clock edge between them. Two such edges put it in a light nap state. Four or more put it in a deep sleep state. Any serial-clock edge brings it back to active and clears the run. No register or command word is involved.

The block also models the readiness of the voltage reference. Nap leaves the reference powered, so the ready flag stays high and a conversion can follow the wake at once. Sleep powers the reference down, so the flag falls as sleep is entered. After a wake from sleep, the flag returns high only once a settling delay has run out. The delay is a parameter counted in system clock cycles and stands for the roughly 2 ms a reference needs to recover. Gating of analog power is left to the blocks that consume these outputs.

Top module: `conv_pwr_mode_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the mode output is active (code 0) and ref_ready is 1. Reset is synchronous and active high.
- R2: A single convert edge that follows a serial-clock edge (or follows reset) leaves the mode at active.
- R3: The second convert edge in a row, with no serial-clock edge since the first, sets the mode to nap (code 1). The new mode is visible on the clock edge that samples the pulse.
- R4: A third convert edge in a row keeps the mode at nap.
- R5: The fourth convert edge in a row sets the mode to sleep (code 2). Further convert edges keep it at sleep. Mode code 3 never appears, and the mode changes only on a cycle that carries a convert or serial-clock pulse.
- R6: A serial-clock edge returns the mode to active from nap or sleep on the edge that samples it. It also restarts the run, so two fresh convert edges are again needed for nap.
- R7: When a convert pulse and a serial-clock pulse arrive in the same cycle, the mode goes to active and that convert edge counts as the first of a new run.
- R8: Entering nap, staying in nap and waking from nap never lower ref_ready. ref_ready falls only on entry to sleep.
- R9: ref_ready is 0 in every cycle in which the mode is sleep. It falls on the same edge on which the mode becomes sleep.
- R10: After a wake from sleep, ref_ready rises exactly SETTLE_CYCLES clock edges after the edge on which the mode became active. It is 0 on every edge before that.
- R11: If sleep is entered again before settling ends, ref_ready stays 0 and the settling count starts over in full at the next wake.
- R12: Serial-clock edges that arrive while the block is active and settling neither restart nor extend the settling count.
- R13: Convert edges that each have a serial-clock edge between them never leave active, however many there are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_rise | input | 1 | One-cycle pulse: convert-start rising edge seen |
| sck_rise | input | 1 | One-cycle pulse: serial-clock rising edge seen |
| pwr_mode | output | 2 | 0 active, 1 nap, 2 sleep |
| ref_ready | output | 1 | Reference settled and usable |

## Verification
If the run counter holds a wrong value, the mode changes one convert edge too early or too late. The error shows on pwr_mode at the very next clock edge, which is why every step of the stimulus table checks the mode. If the run is not cleared, the fault stays hidden until a later run of convert edges reaches nap or sleep too soon, so the bench follows every wake with exactly one, two and four fresh edges. A fault in the settling timer shows only on ref_ready, so that output is checked on each cycle of the window around SETTLE_CYCLES, across a restart by a serial-clock edge, and across a return to sleep before settling ends.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_NAP    = 2'd1,
        PM_SLEEP  = 2'd2
    } pwr_mode_e;

    // Mode reached once a run of back-to-back convert edges has this length.
    function automatic pwr_mode_e mode_for_run(input int run_len,
                                               input int nap_len,
                                               input int sleep_len);
        if (run_len >= sleep_len)
            return PM_SLEEP;
        else if (run_len >= nap_len)
            return PM_NAP;
        else
            return PM_ACTIVE;
    endfunction

endpackage

// File: rtl/cpm_run_counter.sv
module cpm_run_counter #(
    parameter int SLEEP_EDGES = 4,
    localparam int CW = $clog2(SLEEP_EDGES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_rise,
    input  logic          sck_rise,
    output logic [CW-1:0] run_nxt
);
    localparam logic [CW-1:0] RUN_MAX = CW'(SLEEP_EDGES);

    logic [CW-1:0] run_q;

    always_comb begin
        run_nxt = run_q;
        if (sck_rise)
            run_nxt = conv_rise ? CW'(1) : '0;
        else if (conv_rise && run_q != RUN_MAX)
            run_nxt = run_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else
            run_q <= run_nxt;
    end
endmodule

// File: rtl/cpm_mode_fsm.sv
module cpm_mode_fsm
    import cpm_pkg::*;
#(
    parameter int NAP_EDGES   = 2,
    parameter int SLEEP_EDGES = 4,
    localparam int CW = $clog2(SLEEP_EDGES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_rise,
    input  logic          sck_rise,
    input  logic [CW-1:0] run_nxt,
    output pwr_mode_e     mode_q,
    output logic          sleep_enter,
    output logic          sleep_wake
);
    pwr_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (sck_rise)
            mode_d = PM_ACTIVE;
        else if (conv_rise)
            mode_d = mode_for_run(int'(run_nxt), NAP_EDGES, SLEEP_EDGES);
    end

    assign sleep_enter = (mode_d == PM_SLEEP) && (mode_q != PM_SLEEP);
    assign sleep_wake  = (mode_q == PM_SLEEP) && (mode_d != PM_SLEEP);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= PM_ACTIVE;
        else
            mode_q <= mode_d;
    end
endmodule

// File: rtl/cpm_ref_settle.sv
module cpm_ref_settle #(
    parameter int SETTLE_CYCLES = 250000,
    localparam int SW = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_enter,
    input  logic sleep_wake,
    output logic ready_q
);
    localparam logic [SW-1:0] LOAD = SW'(SETTLE_CYCLES - 1);

    logic [SW-1:0] left_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b1;
            busy_q  <= 1'b0;
            left_q  <= '0;
        end else if (sleep_enter) begin
            ready_q <= 1'b0;
            busy_q  <= 1'b0;
            left_q  <= '0;
        end else if (sleep_wake) begin
            busy_q  <= 1'b1;
            left_q  <= LOAD;
        end else if (busy_q) begin
            if (left_q == '0) begin
                ready_q <= 1'b1;
                busy_q  <= 1'b0;
            end else begin
                left_q <= left_q - SW'(1);
            end
        end
    end
endmodule

// File: rtl/conv_pwr_mode_ctrl.sv
module conv_pwr_mode_ctrl
    import cpm_pkg::*;
#(
    parameter int NAP_EDGES     = 2,
    parameter int SLEEP_EDGES   = 4,
    parameter int SETTLE_CYCLES = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_rise,
    input  logic       sck_rise,
    output logic [1:0] pwr_mode,
    output logic       ref_ready
);
    localparam int CW = $clog2(SLEEP_EDGES + 1);

    logic [CW-1:0] run_nxt;
    pwr_mode_e     mode_q;
    logic          sleep_enter;
    logic          sleep_wake;

    cpm_run_counter #(.SLEEP_EDGES(SLEEP_EDGES)) u_run (
        .clk      (clk),
        .rst      (rst),
        .conv_rise(conv_rise),
        .sck_rise (sck_rise),
        .run_nxt  (run_nxt)
    );

    cpm_mode_fsm #(.NAP_EDGES(NAP_EDGES), .SLEEP_EDGES(SLEEP_EDGES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .conv_rise  (conv_rise),
        .sck_rise   (sck_rise),
        .run_nxt    (run_nxt),
        .mode_q     (mode_q),
        .sleep_enter(sleep_enter),
        .sleep_wake (sleep_wake)
    );

    cpm_ref_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .sleep_enter(sleep_enter),
        .sleep_wake (sleep_wake),
        .ready_q    (ref_ready)
    );

    assign pwr_mode = mode_q;
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker (
    input logic       clk,
    input logic       rst,
    input logic       conv_rise,
    input logic       sck_rise,
    input logic [1:0] pwr_mode,
    input logic       ref_ready
);
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        pwr_mode != 2'd3);                                              // R5
    AST_IDLE_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
        (!conv_rise && !sck_rise) |=> $stable(pwr_mode));               // R5
    AST_SLEEP_NEEDS_CONV: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_mode == 2'd2) |-> $past(conv_rise) && !$past(sck_rise)); // R5
    AST_SCK_WAKES: assert property (@(posedge clk) disable iff (rst)
        sck_rise |=> pwr_mode == 2'd0);                                 // R6
    AST_READY_FALLS_ON_SLEEP: assert property (@(posedge clk) disable iff (rst)
        ref_ready |=> ref_ready || pwr_mode == 2'd2);                   // R8
    AST_SLEEP_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        pwr_mode == 2'd2 |-> !ref_ready);                               // R9
    AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd2 && sck_rise) |=> !ref_ready);                 // R10
    AST_READY_RISES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_ready) |-> pwr_mode != 2'd2);                         // R10
endmodule

bind conv_pwr_mode_ctrl cpm_checker u_cpm_checker (
    .clk      (clk),
    .rst      (rst),
    .conv_rise(conv_rise),
    .sck_rise (sck_rise),
    .pwr_mode (pwr_mode),
    .ref_ready(ref_ready)
);

// File: tb/tb_conv_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_conv_pwr_mode_ctrl;
    localparam int SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_rise = 1'b0;
    logic       sck_rise = 1'b0;
    logic [1:0] pwr_mode;
    logic       ref_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    conv_pwr_mode_ctrl #(.NAP_EDGES(2), .SLEEP_EDGES(4), .SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst(rst), .conv_rise(conv_rise), .sck_rise(sck_rise),
        .pwr_mode(pwr_mode), .ref_ready(ref_ready)
    );

    // {conv, sck, expected mode[1:0], expected ready}; one row per cycle
    localparam int NV = 21;
    localparam logic [4:0] VEC [NV] = '{
        5'b10_00_1, // R2 first edge stays active
        5'b10_01_1, // R3 second edge -> nap
        5'b10_01_1, // R4 third edge stays nap
        5'b01_00_1, // R6 R8 wake from nap, ready kept
        5'b10_00_1, // R6 run restarted
        5'b10_01_1, // R6 nap again after two
        5'b01_00_1, // R6
        5'b11_00_1, // R7 both in one cycle -> active, run=1
        5'b10_01_1, // R7 one more edge -> nap
        5'b10_01_1, // R4
        5'b10_10_0, // R5 R9 fourth edge -> sleep, ready drops
        5'b10_10_0, // R5 stays sleep
        5'b00_10_0, // R5 idle holds sleep
        5'b01_00_0, // R10 wake edge E0
        5'b00_00_0, // R10 E1
        5'b01_00_0, // R12 sck while settling, E2
        5'b00_00_0, // R10 E3
        5'b00_00_0, // R10 E4
        5'b00_00_0, // R10 E5
        5'b00_00_1, // R10 R12 ready at E6
        5'b00_00_1  // R10
    };

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic s);
        conv_rise = c;
        sck_rise  = s;
        @(negedge clk);
    endtask

    task automatic expect_state(input string tag, input int m, input int r);
        check({tag, " mode"}, int'(pwr_mode), m);
        check({tag, " ready"}, int'(ref_ready), r);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_state("R1 in reset", 0, 1);
        rst = 1'b0;
        @(negedge clk);
        expect_state("R1 after reset", 0, 1);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][4], VEC[i][3]);
            expect_state($sformatf("table row %0d", i), int'(VEC[i][2:1]), int'(VEC[i][0]));
        end

        // R11: re-sleep during settling, then full restart
        repeat (4) step(1, 0);
        expect_state("R11 sleep", 2, 0);
        step(0, 1);
        step(0, 0);
        step(0, 0);
        repeat (3) step(1, 0);
        expect_state("R11 nap while settling", 1, 0);
        step(1, 0);
        expect_state("R11 back to sleep", 2, 0);
        step(0, 0); step(0, 0); step(0, 0);
        expect_state("R11 still low", 2, 0);
        step(0, 1);
        expect_state("R11 wake", 0, 0);
        for (int k = 1; k < SETTLE; k++) begin
            step(0, 0);
            check($sformatf("R11 R10 low at edge %0d", k), int'(ref_ready), 0);
        end
        step(0, 0);
        check("R11 R10 ready after full count", int'(ref_ready), 1);

        // R13: alternating convert and serial-clock edges
        for (int k = 0; k < 10; k++) begin
            step(1, 0);
            check("R13 alternating conv", int'(pwr_mode), 0);
            step(0, 1);
        end

        // R1: reset out of sleep
        repeat (5) step(1, 0);
        expect_state("R5 sleep before reset", 2, 0);
        rst = 1'b1;
        step(0, 0);
        rst = 1'b0;
        expect_state("R1 reset from sleep", 0, 1);
        step(1, 0);
        check("R1 R2 run cleared by reset", int'(pwr_mode), 0);
        step(0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule